// File: doc/BRIEF.md
# ECC Write Check-Bit Error Injector

This block sits on the memory write path, just after check-bit generation. Each beat it receives carries a 64-bit data word and the 8 check bits computed for it. In normal operation both go on to memory as they came. In diagnostic mode, selected check bits are flipped under a programmable 8-bit mask, so that chosen errors reach memory on purpose. The read path can then show that it detects and reports them.

Check bit k belongs to data byte lane k. A mask bit therefore chooses one lane's check bit. The data bits are never touched. The mask and the enable are loaded together through a one-cycle write strobe. The stage holds one output register with a valid/ready handshake on each side. The mask and enable values are sampled when a word is accepted, so a reprogramming never alters a word that is already held.

Top module: `eccFlipStage`

## Requirements
- R1: The output data word equals the accepted input data word bit for bit, whatever the mask and enable are.
- R2: When the enable is 1, output check bit k equals accepted check bit k inverted if mask bit k is 1, and unchanged if mask bit k is 0, for each k from 0 to 7. Mask bit k sits at `cfgMask[k]` and acts on `inCheck[k]`, the check bit of data byte lane k, which is `inData[8k+7:8k]`.
- R3: When the enable is 0, the output check bits equal the accepted check bits for any mask value, including 8'hFF.
- R4: After reset the mask is 8'h00, the enable is 0 and `outValid` is 0. A word accepted before any configuration write therefore leaves with its check bits unchanged.
- R5: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData` and `outCheck` keep their values on the next cycle.
- R6: `inReady` is 1 exactly when `outValid` is 0 or `outReady` is 1. A word is accepted on a rising edge where `inValid` and `inReady` are both 1.
- R7: A configuration write (`cfgWe` = 1) takes effect only for words accepted on later edges. A word accepted on the same edge as the write, and any word already held, uses the values from before the write.
- R8: A word accepted on an edge appears with `outValid` = 1 right after that edge. `outValid` falls after an edge where `outReady` is 1 and no new word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Loads `cfgMask` and `cfgEnable` on this edge |
| cfgMask | input | 8 | Per-lane check-bit invert mask to load |
| cfgEnable | input | 1 | Diagnostic enable to load |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Stage can accept a beat |
| inData | input | 64 | Data word, lane k in bits 8k+7:8k |
| inCheck | input | 8 | Check bits, bit k for lane k |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts the output beat |
| outData | output | 64 | Data word, unchanged |
| outCheck | output | 8 | Check bits after optional inversion |

## Verification
The hardest case to reach is a configuration write that lands while a word is stalled in the output register, or on the same edge a new word is accepted. Random traffic rarely lines these up.

Directed sequences hold `outReady` low, write a new mask and enable, and then release the stall, checking that the held word keeps its old check bits. Another sequence writes the configuration on an accepting edge and expects the old mask on that word and the new mask on the next one. Random stimulus from a fixed seed then mixes stalls, writes and masks to cover the remaining combinations.

// File: rtl/eccFlipPkg.sv
package eccFlipPkg;
  localparam int LANES = 8;
  localparam int LANE_BITS = 8;
  localparam int DATA_W = LANES * LANE_BITS;

  typedef struct packed {
    logic             load;
    logic             flipEn;
    logic [LANES-1:0] mask;
  } strobe_t;
endpackage

// File: rtl/eccFlipCtrl.sv
module eccFlipCtrl
  import eccFlipPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [LANES-1:0] cfgMask,
  input  logic             cfgEnable,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic [LANES-1:0] maskNow,
  output logic             enNow,
  output strobe_t          strb
);
  logic validQ;

  assign inReady  = !validQ || outReady;
  assign outValid = validQ;
  assign strb.load   = inValid && inReady;
  assign strb.flipEn = enNow;
  assign strb.mask   = maskNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strb.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskNow <= '0;
      enNow   <= 1'b0;
    end else if (cfgWe) begin
      maskNow <= cfgMask;
      enNow   <= cfgEnable;
    end
  end
endmodule

// File: rtl/eccFlipPath.sv
module eccFlipPath
  import eccFlipPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [LANES-1:0]  inCheck,
  output logic [DATA_W-1:0] outData,
  output logic [LANES-1:0]  outCheck
);
  logic [LANES-1:0] flipped;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign flipped[k] = inCheck[k] ^ (strb.flipEn & strb.mask[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      outCheck <= '0;
    end else if (strb.load) begin
      outData  <= inData;
      outCheck <= flipped;
    end
  end
endmodule

// File: rtl/eccFlipStage.sv
module eccFlipStage
  import eccFlipPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [LANES-1:0]  cfgMask,
  input  logic              cfgEnable,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic [LANES-1:0]  inCheck,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [LANES-1:0]  outCheck
);
  strobe_t          strb;
  logic [LANES-1:0] maskNow;
  logic             enNow;

  eccFlipCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMask(cfgMask),
    .cfgEnable(cfgEnable), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .maskNow(maskNow),
    .enNow(enNow), .strb(strb)
  );

  eccFlipPath path_i (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .inCheck(inCheck), .outData(outData), .outCheck(outCheck)
  );
endmodule

// File: rtl/eccFlipStage_chk.sv
module eccFlipStage_chk
  import eccFlipPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] inData,
  input logic [LANES-1:0]  inCheck,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic [LANES-1:0]  outCheck,
  input logic [LANES-1:0]  maskNow,
  input logic              enNow
);
  assert_data_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid && outData == $past(inData)));

  assert_check_flip_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && enNow) |=> (outCheck == ($past(inCheck) ^ $past(maskNow))));

  assert_check_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !enNow) |=> (outCheck == $past(inCheck)));

  assert_reset_cfg_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (maskNow == '0 && !enNow && !outValid));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outCheck)));

  assert_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    inReady == (!outValid || outReady));

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && !(inValid && inReady)) |=> !outValid);
endmodule

bind eccFlipStage eccFlipStage_chk chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inData(inData), .inCheck(inCheck), .outValid(outValid),
  .outReady(outReady), .outData(outData), .outCheck(outCheck),
  .maskNow(maskNow), .enNow(enNow)
);

// File: tb/eccFlipStage_tb_top.sv
module eccFlipStage_tb_top;
  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgMask = '0;
  logic        cfgEnable = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inData = '0;
  logic [7:0]  inCheck = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outData;
  logic [7:0]  outCheck;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic        mValid = 1'b0;
  logic [63:0] mData = '0;
  logic [7:0]  mCheck = '0;
  logic [7:0]  mMask = '0;
  logic        mEn = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  eccFlipStage dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMask(cfgMask),
    .cfgEnable(cfgEnable), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inCheck(inCheck), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outCheck(outCheck)
  );

  function automatic logic [7:0] expFlip(logic [7:0] c, logic [7:0] m, logic e);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = (e && m[k]) ? ~c[k] : c[k];
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge, predict, advance one edge, compare at the next negedge.
  task automatic step(string tag, logic iv, logic [63:0] d, logic [7:0] c,
                      logic ordy, logic we, logic [7:0] m, logic e);
    logic expReady;
    inValid = iv; inData = d; inCheck = c; outReady = ordy;
    cfgWe = we; cfgMask = m; cfgEnable = e;
    #1;
    expReady = !mValid || ordy;
    chk("R6 inReady", {63'd0, inReady}, {63'd0, expReady});
    if (iv && expReady) begin
      mValid = 1'b1; mData = d; mCheck = expFlip(c, mMask, mEn);
    end else if (ordy) begin
      mValid = 1'b0;
    end
    if (we) begin mMask = m; mEn = e; end
    @(posedge clk);
    @(negedge clk);
    chk("R8 outValid", {63'd0, outValid}, {63'd0, mValid});
    if (mValid) begin
      chk("R1 outData", outData, mData);
      chk({tag, " outCheck"}, {56'd0, outCheck}, {56'd0, mCheck});
    end
  endtask

  initial begin
    repeat (WatchdogCycles) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  c;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R4 outValid in reset", {63'd0, outValid}, 64'd0);
    chk("R6 inReady in reset", {63'd0, inReady}, 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R4 outValid after reset", {63'd0, outValid}, 64'd0);

    // R4: reset config leaves check bits intact
    step("R4", 1, 64'h0123_4567_89AB_CDEF, 8'hA5, 1, 0, 8'h00, 0);
    // R3: enable off, full mask written, no flips
    step("R3", 1, 64'hFFFF_0000_FFFF_0000, 8'h3C, 1, 1, 8'hFF, 0);
    step("R3", 1, 64'h1111_2222_3333_4444, 8'h3C, 1, 0, 8'h00, 0);
    // R2: each lane alone
    for (int k = 0; k < 8; k++) begin
      step("R2 lane", 0, 64'd0, 8'h00, 1, 1, 8'(1 << k), 1);
      step("R2 lane", 1, {8{8'(k)}}, 8'h5A, 1, 0, 8'h00, 0);
    end
    // R7: write on the accepting edge uses old mask; next word uses new
    step("R7 same edge", 1, 64'hDEAD_BEEF_0000_0001, 8'h00, 1, 1, 8'h0F, 1);
    step("R7 next word", 1, 64'hDEAD_BEEF_0000_0002, 8'h00, 1, 0, 8'h00, 0);
    // R5/R7: stall a word, reprogram during the stall, then release
    step("R5 load", 1, 64'hCAFE_F00D_1234_5678, 8'hC3, 0, 0, 8'h00, 0);
    step("R5 hold", 1, 64'h0, 8'hFF, 0, 1, 8'hF0, 1);
    step("R7 held", 0, 64'h0, 8'h00, 0, 1, 8'h00, 0);
    step("R5 release", 0, 64'h0, 8'h00, 1, 0, 8'h00, 0);
    step("R7 after", 1, 64'h7777_7777_7777_7777, 8'h81, 1, 0, 8'h00, 0);
    step("R8 drain", 0, 64'h0, 8'h00, 1, 0, 8'h00, 0);

    // Random mix: stalls, writes, masks (R1 R2 R3 R5 R6 R7 R8)
    for (int i = 0; i < 2000; i++) begin
      d = {$urandom, $urandom};
      c = 8'($urandom);
      step("R2/R3 random", ($urandom % 4) != 0, d, c, ($urandom % 3) != 0,
           ($urandom % 6) == 0, 8'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule